// File: doc/BRIEF.md
# Token-Gated Shared Translation Cache with Bypass Store

This block holds address translations for many warps spread over several cores. It has two stores. The main one is a set-associative shared TLB. Beside it sits a small fully associative bypass store. Each lookup names a core, a warp and a virtual page number, and it searches both stores in the same cycle. One cycle later the block reports either a physical page number or a miss. On a miss the requester starts a page walk, and the walk's answer comes back to the block on the fill port.

Only some warps may write into the shared TLB. Each core owns an equal share of a fixed pool of permits. Inside each core, the permits go to a run of consecutive warps, and a free-running LFSR picks where that run starts. The run is chosen again at the start of every fixed-length epoch. A fill from a warp that holds a permit goes into the shared TLB. A fill from any other warp goes into the bypass store.

A translation lives in only one of the two stores at a time. The current permit map is an output, so each core can see which of its warps may write into the shared TLB. The page walker is not part of this block.

Top module: `shared_tlb_tokfill`

## Requirements
- R1: A fill from a warp whose permit bit is set writes the shared TLB. A later lookup of that page from any warp hits with `rs_src` = 0 (shared) and returns the filled page number.
- R2: A fill from a warp without a permit, for a page that is not in the shared TLB, writes the bypass store. A later lookup hits with `rs_src` = 1 (bypass).
- R3: A lookup presented in the cycle ending at edge k gives `rs_valid` = 1 after edge k, with `rs_core`, `rs_warp` and `rs_vpn` echoing the request. With no lookup, `rs_valid` is 0 after the next edge.
- R4: A page that is in neither store gives `rs_valid` = 1 with `rs_hit` = 0, so that a walk can be started.
- R5: `token_mask` bit `c*WARPS_PER_CORE + w` is the permit of warp w on core c. Every core always holds exactly `TOKENS_TOTAL/NUM_CORES` permits. After reset, warps 0 to `TOKENS_TOTAL/NUM_CORES - 1` of each core hold them.
- R6: `token_mask` can change only at the clock edges whose count since reset release is a whole multiple of `EPOCH_CYCLES`.
- R7: A permitted fill for a page that is held in the bypass store removes it from there. After that, a lookup hits in the shared TLB and never in both stores.
- R8: A fill without a permit, for a page that is already in the shared TLB, rewrites that shared entry in place and adds nothing to the bypass store.
- R9: The set index of the shared TLB is the low `log2(TLB_SETS)` bits of the page number. When a set is full, a new page replaces the least recently filled or hit entry.
- R10: A new page written into the bypass store goes to the slot after the one last written, in round-robin order, whether or not the slot is occupied.
- R11: A fill for a page already held in the store it targets rewrites that entry's page number and does not take a new slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_core | input | log2(NUM_CORES) | Requesting core |
| lk_warp | input | log2(WARPS_PER_CORE) | Requesting warp within the core |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| fl_valid | input | 1 | Walk result present |
| fl_core | input | log2(NUM_CORES) | Core whose miss caused the walk |
| fl_warp | input | log2(WARPS_PER_CORE) | Warp whose miss caused the walk |
| fl_vpn | input | VPN_W | Virtual page of the walk result |
| fl_ppn | input | PPN_W | Physical page of the walk result |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | Translation found in either store |
| rs_src | output | 1 | Store that hit: 0 shared, 1 bypass |
| rs_ppn | output | PPN_W | Physical page on a hit, zero on a miss |
| rs_core | output | log2(NUM_CORES) | Echoed core |
| rs_warp | output | log2(WARPS_PER_CORE) | Echoed warp |
| rs_vpn | output | VPN_W | Echoed virtual page |
| token_mask | output | NUM_CORES*WARPS_PER_CORE | Current permit map |

## Verification
The stimulus first separates permitted from unpermitted fills for new pages. It then crosses each kind of fill with a page already held in the other store, which exposes any duplicate entry or wrong routing. One set of the shared TLB is filled past capacity after a hit has touched its oldest entry, so eviction by fill order alone can be told apart from true recency. The bypass store is filled beyond its depth while a stale invalidated slot and an in-place rewrite are pending, which shows whether the pointer skips slots or advances on updates. Over three epochs the permit map is watched every cycle, and routing is checked again with warps taken from the map as it then stands.

// File: rtl/tlbtok_pkg.sv
// Shared types for the token-gated translation cache.
package tlbtok_pkg;
    // Which store produced a hit.
    typedef enum logic {
        SRC_SHARED = 1'b0,
        SRC_BYPASS = 1'b1
    } hit_src_e;
endpackage

// File: rtl/tok_alloc.sv
// Permit allocator: gives TOK_PER_CORE permits to each core as a run of
// consecutive warps. An LFSR picks the start of each run, and the runs are
// chosen again once per epoch.
// Assumes WARPS is a power of two and TOK_PER_CORE <= WARPS.
module tok_alloc #(
    parameter int          NUM_CORES    = 4,
    parameter int          WARPS        = 8,
    parameter int          TOK_PER_CORE = 2,
    parameter int          EPOCH        = 4096,
    parameter logic [15:0] SEED         = 16'hACE1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [NUM_CORES*WARPS-1:0] mask
);
    localparam int LFSR_W = 16;
    localparam int CNT_W  = (EPOCH > 1) ? $clog2(EPOCH) : 1;

    logic [LFSR_W-1:0]          lfsr_q;
    logic [CNT_W-1:0]           ep_cnt_q;
    logic [NUM_CORES*WARPS-1:0] mask_q;
    logic [NUM_CORES*WARPS-1:0] next_mask;

    // Build the next permit map from rotated LFSR bits, one run per core.
    always_comb begin
        next_mask = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            int off;
            off = int'((lfsr_q >> ((c * 5) % LFSR_W)) & LFSR_W'(WARPS - 1));
            for (int t = 0; t < TOK_PER_CORE; t++) begin
                next_mask[c*WARPS + ((off + t) % WARPS)] = 1'b1;
            end
        end
    end

    // Step the LFSR every cycle, count the epoch, and load a new map at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q   <= SEED;
            ep_cnt_q <= '0;
            for (int c = 0; c < NUM_CORES; c++) begin
                for (int w = 0; w < WARPS; w++) begin
                    mask_q[c*WARPS + w] <= (w < TOK_PER_CORE);
                end
            end
        end else begin
            lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
            if (ep_cnt_q == CNT_W'(EPOCH - 1)) begin
                ep_cnt_q <= '0;
                mask_q   <= next_mask;
            end else begin
                ep_cnt_q <= ep_cnt_q + 1'b1;
            end
        end
    end

    assign mask = mask_q;
endmodule

// File: rtl/stlb_array.sv
// Set-associative shared TLB with true LRU kept as per-way age counters.
// A lookup searches its set combinationally. A fill rewrites a matching way,
// or else the lowest invalid way, or else the oldest way.
// Assumes SETS and WAYS are powers of two and both at least 2. When a fill
// and a lookup hit land in the same cycle, only the fill updates the ages.
module stlb_array #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fl_en,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn,
    output logic             fl_present
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic             vld_q [SETS][WAYS];
    logic [VPN_W-1:0] tag_q [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q [SETS][WAYS];
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    logic [SET_W-1:0] lk_set, fl_set, touch_set;
    logic [WAY_W-1:0] lk_way, hit_way, inv_way, lru_way, fl_way, touch_way;
    logic             inv_found, touch_en;

    assign lk_set = lk_vpn[SET_W-1:0];
    assign fl_set = fl_vpn[SET_W-1:0];

    // Search the lookup's set for a valid entry with a matching page.
    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        lk_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_vpn) begin
                lk_hit = 1'b1;
                lk_ppn = ppn_q[lk_set][w];
                lk_way = WAY_W'(w);
            end
        end
    end

    // Pick the fill way: the matching way, else the lowest invalid way, else the oldest.
    always_comb begin
        fl_present = 1'b0;
        hit_way    = '0;
        inv_found  = 1'b0;
        inv_way    = '0;
        lru_way    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vld_q[fl_set][w] && tag_q[fl_set][w] == fl_vpn) begin
                fl_present = 1'b1;
                hit_way    = WAY_W'(w);
            end
            if (!vld_q[fl_set][w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
            if (age_q[fl_set][w] == WAY_W'(WAYS - 1)) begin
                lru_way = WAY_W'(w);
            end
        end
        fl_way = fl_present ? hit_way : (inv_found ? inv_way : lru_way);
    end

    // Choose which access refreshes recency this cycle; a fill wins.
    always_comb begin
        touch_en  = fl_en || (lk_valid && lk_hit);
        touch_set = fl_en ? fl_set : lk_set;
        touch_way = fl_en ? fl_way : lk_way;
    end

    // Write the tag and page payload of the filled way.
    always_ff @(posedge clk) begin
        if (fl_en) begin
            tag_q[fl_set][fl_way] <= fl_vpn;
            ppn_q[fl_set][fl_way] <= fl_ppn;
        end
    end

    // Keep valid bits and ages: the touched way becomes youngest, younger ones age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    vld_q[s][w] <= 1'b0;
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            if (fl_en) begin
                vld_q[fl_set][fl_way] <= 1'b1;
            end
            if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way) begin
                        age_q[touch_set][w] <= '0;
                    end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
                        age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/byp_cache.sv
// Small fully associative bypass store for pages filled by warps without a
// permit. A new page goes to the round-robin slot, and a page already held is
// rewritten in place. An invalidate clears a matching entry.
// Assumes ENTRIES is at least 2 and that wr_en and inv_en are never both high.
module byp_cache #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             wr_en,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn
);
    localparam int PTR_W = $clog2(ENTRIES);

    logic             vld_q [ENTRIES];
    logic [VPN_W-1:0] tag_q [ENTRIES];
    logic [PPN_W-1:0] ppn_q [ENTRIES];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] fl_idx, wr_idx;
    logic             fl_match;

    // Search every entry for the lookup page.
    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (vld_q[e] && tag_q[e] == lk_vpn) begin
                lk_hit = 1'b1;
                lk_ppn = ppn_q[e];
            end
        end
    end

    // Search every entry for the fill page and choose the slot to write.
    always_comb begin
        fl_match = 1'b0;
        fl_idx   = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (vld_q[e] && tag_q[e] == fl_vpn) begin
                fl_match = 1'b1;
                fl_idx   = PTR_W'(e);
            end
        end
        wr_idx = fl_match ? fl_idx : ptr_q;
    end

    // Write the payload of the chosen slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= fl_vpn;
            ppn_q[wr_idx] <= fl_ppn;
        end
    end

    // Keep valid bits and the replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                vld_q[e] <= 1'b0;
            end
        end else begin
            if (wr_en) begin
                vld_q[wr_idx] <= 1'b1;
                if (!fl_match) begin
                    ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
                end
            end
            if (inv_en && fl_match) begin
                vld_q[fl_idx] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/shared_tlb_tokfill.sv
// Top level: one lookup port, one fill port, and a registered result one cycle
// after the lookup. A fill goes to the shared TLB if its warp holds a permit or
// if the page is already there. Otherwise it goes to the bypass store.
// Assumes NUM_CORES and WARPS_PER_CORE are powers of two and at least 2, and
// that TOKENS_TOTAL divides evenly among the cores. A lookup in the same cycle
// as a fill sees the stores as they were before that fill.
module shared_tlb_tokfill #(
    parameter int          NUM_CORES      = 4,
    parameter int          WARPS_PER_CORE = 8,
    parameter int          TOKENS_TOTAL   = 8,
    parameter int          TLB_SETS       = 16,
    parameter int          TLB_WAYS       = 4,
    parameter int          BYP_ENTRIES    = 8,
    parameter int          VPN_W          = 20,
    parameter int          PPN_W          = 20,
    parameter int          EPOCH_CYCLES   = 4096,
    parameter logic [15:0] LFSR_SEED      = 16'hACE1,
    localparam int         CORE_W         = $clog2(NUM_CORES),
    localparam int         WARP_W         = $clog2(WARPS_PER_CORE),
    localparam int         MASK_W         = NUM_CORES * WARPS_PER_CORE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [CORE_W-1:0] lk_core,
    input  logic [WARP_W-1:0] lk_warp,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              fl_valid,
    input  logic [CORE_W-1:0] fl_core,
    input  logic [WARP_W-1:0] fl_warp,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [PPN_W-1:0]  fl_ppn,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_src,
    output logic [PPN_W-1:0]  rs_ppn,
    output logic [CORE_W-1:0] rs_core,
    output logic [WARP_W-1:0] rs_warp,
    output logic [VPN_W-1:0]  rs_vpn,
    output logic [MASK_W-1:0] token_mask
);
    import tlbtok_pkg::*;

    localparam int TOK_PER_CORE = TOKENS_TOTAL / NUM_CORES;

    logic             tlb_hit, byp_hit, tlb_present, fl_has_tok;
    logic             tlb_fill, byp_wr, byp_inv;
    logic [PPN_W-1:0] tlb_ppn, byp_ppn;
    hit_src_e         src_q;

    tok_alloc #(
        .NUM_CORES   (NUM_CORES),
        .WARPS       (WARPS_PER_CORE),
        .TOK_PER_CORE(TOK_PER_CORE),
        .EPOCH       (EPOCH_CYCLES),
        .SEED        (LFSR_SEED)
    ) u_tok (
        .clk  (clk),
        .rst_n(rst_n),
        .mask (token_mask)
    );

    // Route the fill using the permit map that holds in this cycle.
    always_comb begin
        fl_has_tok = token_mask[{fl_core, fl_warp}];
        tlb_fill   = fl_valid && (fl_has_tok || tlb_present);
        byp_wr     = fl_valid && !fl_has_tok && !tlb_present;
        byp_inv    = fl_valid && fl_has_tok;
    end

    stlb_array #(
        .SETS (TLB_SETS),
        .WAYS (TLB_WAYS),
        .VPN_W(VPN_W),
        .PPN_W(PPN_W)
    ) u_stlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_vpn    (lk_vpn),
        .lk_hit    (tlb_hit),
        .lk_ppn    (tlb_ppn),
        .fl_en     (tlb_fill),
        .fl_vpn    (fl_vpn),
        .fl_ppn    (fl_ppn),
        .fl_present(tlb_present)
    );

    byp_cache #(
        .ENTRIES(BYP_ENTRIES),
        .VPN_W  (VPN_W),
        .PPN_W  (PPN_W)
    ) u_byp (
        .clk   (clk),
        .rst_n (rst_n),
        .lk_vpn(lk_vpn),
        .lk_hit(byp_hit),
        .lk_ppn(byp_ppn),
        .wr_en (byp_wr),
        .inv_en(byp_inv),
        .fl_vpn(fl_vpn),
        .fl_ppn(fl_ppn)
    );

    // Register the merged result of both searches together with the requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            src_q    <= SRC_SHARED;
            rs_ppn   <= '0;
            rs_core  <= '0;
            rs_warp  <= '0;
            rs_vpn   <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_hit   <= lk_valid && (tlb_hit || byp_hit);
            src_q    <= (!tlb_hit && byp_hit) ? SRC_BYPASS : SRC_SHARED;
            rs_ppn   <= tlb_hit ? tlb_ppn : (byp_hit ? byp_ppn : '0);
            rs_core  <= lk_core;
            rs_warp  <= lk_warp;
            rs_vpn   <= lk_vpn;
        end
    end

    assign rs_src = src_q;
endmodule

// File: rtl/tlbtok_chk.sv
// Assertion checker for shared_tlb_tokfill, attached with bind below.
// It keeps its own epoch counter and does not use the allocator's.
module tlbtok_chk #(
    parameter int NUM_CORES = 4,
    parameter int WARPS     = 8,
    parameter int TPC       = 2,
    parameter int EPOCH     = 4096
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       lk_valid,
    input logic                       rs_valid,
    input logic [NUM_CORES*WARPS-1:0] token_mask,
    input logic                       tlb_hit,
    input logic                       byp_hit,
    input logic                       fl_valid,
    input logic                       fl_has_tok,
    input logic                       byp_wr
);
    localparam int CNT_W = (EPOCH > 1) ? $clog2(EPOCH) : 1;
    logic [CNT_W-1:0] ep_q;

    // Count cycles since reset release, modulo the epoch length.
    always_ff @(posedge clk) begin
        if (!rst_n) ep_q <= '0;
        else        ep_q <= (ep_q == CNT_W'(EPOCH - 1)) ? '0 : ep_q + 1'b1;
    end

    a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);
    a_r6_epoch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_q != '0) |-> $stable(token_mask));
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> !(tlb_hit && byp_hit));
    a_r1_permit_not_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_has_tok) |-> !byp_wr);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        a_r5_core_tokens: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(token_mask[c*WARPS +: WARPS]) == TPC);
    end
endmodule

bind shared_tlb_tokfill tlbtok_chk #(
    .NUM_CORES(NUM_CORES),
    .WARPS    (WARPS_PER_CORE),
    .TPC      (TOKENS_TOTAL / NUM_CORES),
    .EPOCH    (EPOCH_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .rs_valid  (rs_valid),
    .token_mask(token_mask),
    .tlb_hit   (tlb_hit),
    .byp_hit   (byp_hit),
    .fl_valid  (fl_valid),
    .fl_has_tok(fl_has_tok),
    .byp_wr    (byp_wr)
);

// File: tb/sim_shared_tlb_tokfill.sv
// Scoreboard bench: lookup tasks queue the expected result, and a monitor
// pops the queue and compares each result as it appears.
module sim_shared_tlb_tokfill;
    localparam int EPOCH = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, fl_valid = 1'b0;
    logic [1:0]  lk_core = '0, fl_core = '0;
    logic [2:0]  lk_warp = '0, fl_warp = '0;
    logic [19:0] lk_vpn = '0, fl_vpn = '0, fl_ppn = '0;
    logic        rs_valid, rs_hit, rs_src;
    logic [19:0] rs_ppn, rs_vpn;
    logic [1:0]  rs_core;
    logic [2:0]  rs_warp;
    logic [31:0] token_mask;

    always #2 clk = ~clk;

    shared_tlb_tokfill u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_core(lk_core), .lk_warp(lk_warp), .lk_vpn(lk_vpn),
        .fl_valid(fl_valid), .fl_core(fl_core), .fl_warp(fl_warp), .fl_vpn(fl_vpn),
        .fl_ppn(fl_ppn),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_src(rs_src), .rs_ppn(rs_ppn),
        .rs_core(rs_core), .rs_warp(rs_warp), .rs_vpn(rs_vpn), .token_mask(token_mask)
    );

    typedef struct {
        int          c;
        int          w;
        logic [19:0] vpn;
        bit          hit;
        bit          src;
        logic [19:0] ppn;
        string       req;
    } exp_t;

    exp_t q[$];
    int   checks = 0, errs = 0;
    int   mon_checks = 0, mon_errs = 0;
    int   ep_checks = 0, ep_errs = 0;
    int   cyc = 0;
    bit   done = 1'b0, wd = 1'b0;

    // Count clock edges since reset release.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input int c, input int w, input logic [19:0] vpn,
                          input bit hit, input bit src, input logic [19:0] ppn,
                          input string req);
        exp_t e;
        @(negedge clk);
        lk_valid = 1'b1; lk_core = 2'(c); lk_warp = 3'(w); lk_vpn = vpn;
        e.c = c; e.w = w; e.vpn = vpn; e.hit = hit; e.src = src; e.ppn = ppn; e.req = req;
        q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic fill(input int c, input int w, input logic [19:0] vpn,
                        input logic [19:0] ppn);
        @(negedge clk);
        fl_valid = 1'b1; fl_core = 2'(c); fl_warp = 3'(w); fl_vpn = vpn; fl_ppn = ppn;
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    // Monitor: compare each result with the front of the queue (R3, R4 and others).
    always @(negedge clk) begin
        if (rst_n && rs_valid) begin
            mon_checks++;
            if (q.size() == 0) begin
                mon_errs++;
                $display("FAIL R3 unexpected result: actual vpn %0h expected none", rs_vpn);
            end else begin
                exp_t e;
                bit   ok;
                e  = q.pop_front();
                ok = (rs_hit == e.hit) && (rs_core == 2'(e.c)) && (rs_warp == 3'(e.w)) &&
                     (rs_vpn == e.vpn) && (!e.hit || (rs_src == e.src && rs_ppn == e.ppn));
                if (!ok) begin
                    mon_errs++;
                    $display("FAIL %s vpn %0h: actual hit=%0b src=%0b ppn=%0h c=%0d w=%0d expected hit=%0b src=%0b ppn=%0h c=%0d w=%0d",
                             e.req, e.vpn, rs_hit, rs_src, rs_ppn, rs_core, rs_warp,
                             e.hit, e.src, e.ppn, e.c, e.w);
                end
            end
        end
    end

    // Permit-map monitor: changes only on epoch edges (R6), and each core always holds two (R5).
    logic [31:0] prev_mask = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (token_mask !== prev_mask && (cyc % EPOCH) != 0) begin
                ep_errs++;
                $display("FAIL R6 map changed at edge %0d: actual %0h expected %0h",
                         cyc, token_mask, prev_mask);
            end
            if (cyc > 0 && (cyc % EPOCH) == 0) begin
                for (int c = 0; c < 4; c++) begin
                    ep_checks++;
                    if ($countones(token_mask[c*8 +: 8]) != 2) begin
                        ep_errs++;
                        $display("FAIL R5 core %0d permits: actual %0d expected 2",
                                 c, $countones(token_mask[c*8 +: 8]));
                    end
                end
                ep_checks++;
            end
        end
        prev_mask = token_mask;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
    end

    // Main stimulus.
    initial begin
        int tw, nw;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rs_valid == 1'b0, "R3", "idle result after reset", 64'(rs_valid), 64'd0);
        chk(token_mask == 32'h0303_0303, "R5", "reset permit map", 64'(token_mask), 64'h03030303);

        lookup(1, 2, 20'h00100, 1'b0, 1'b0, 20'h0, "R4");
        fill(0, 0, 20'h00100, 20'h0AAAA);
        lookup(1, 3, 20'h00100, 1'b1, 1'b0, 20'h0AAAA, "R1");
        fill(0, 5, 20'h00201, 20'h0BBBB);
        lookup(2, 6, 20'h00201, 1'b1, 1'b1, 20'h0BBBB, "R2");
        fill(2, 7, 20'h00100, 20'h0CCCC);
        lookup(0, 4, 20'h00100, 1'b1, 1'b0, 20'h0CCCC, "R8");
        fill(1, 1, 20'h00201, 20'h0DDDD);
        lookup(3, 2, 20'h00201, 1'b1, 1'b0, 20'h0DDDD, "R7");
        fill(3, 6, 20'h00305, 20'h00001);
        fill(3, 6, 20'h00305, 20'h00002);
        lookup(3, 6, 20'h00305, 1'b1, 1'b1, 20'h00002, "R11");

        // R9: fill set 8 with four pages, touch the oldest, then add a fifth.
        for (int i = 0; i < 4; i++) fill(0, 1, 20'(32'h008 + 32'h10 * i), 20'(32'h10 + i));
        lookup(0, 1, 20'h00008, 1'b1, 1'b0, 20'h00010, "R9");
        fill(0, 1, 20'h00048, 20'h00014);
        lookup(0, 1, 20'h00018, 1'b0, 1'b0, 20'h0, "R9");
        lookup(0, 1, 20'h00008, 1'b1, 1'b0, 20'h00010, "R9");
        lookup(0, 1, 20'h00048, 1'b1, 1'b0, 20'h00014, "R9");

        // R10: slot 0 holds an invalidated page, slot 1 holds 0x305, pointer at 2.
        for (int i = 0; i < 8; i++) fill(1, 4, 20'(32'h400 + i), 20'(32'h50 + i));
        lookup(1, 4, 20'h00305, 1'b0, 1'b0, 20'h0, "R10");
        lookup(1, 4, 20'h00400, 1'b1, 1'b1, 20'h00050, "R10");
        lookup(1, 4, 20'h00407, 1'b1, 1'b1, 20'h00057, "R10");
        fill(1, 4, 20'h00408, 20'h00058);
        lookup(1, 4, 20'h00400, 1'b0, 1'b0, 20'h0, "R10");
        lookup(1, 4, 20'h00401, 1'b1, 1'b1, 20'h00051, "R10");
        lookup(1, 4, 20'h00408, 1'b1, 1'b1, 20'h00058, "R10");

        // Run past three epochs, then route fills using the current map (R1, R2, R6).
        while (cyc < 3 * EPOCH + 4) @(negedge clk);
        tw = -1; nw = -1;
        for (int w = 0; w < 8; w++) begin
            if (token_mask[16 + w] && tw < 0) tw = w;
            if (!token_mask[16 + w] && nw < 0) nw = w;
        end
        chk(tw >= 0 && nw >= 0, "R5", "core 2 has permitted and unpermitted warps",
            64'(tw), 64'(nw));
        fill(2, tw, 20'h00777, 20'h07777);
        lookup(2, nw, 20'h00777, 1'b1, 1'b0, 20'h07777, "R1");
        fill(2, nw, 20'h00778, 20'h07778);
        lookup(2, tw, 20'h00778, 1'b1, 1'b1, 20'h07778, "R2");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R3", "results outstanding", 64'(q.size()), 64'd0);
        chk(ep_checks >= 15, "R6", "epoch edges observed", 64'(ep_checks), 64'd15);
        done = 1'b1;
    end

    // Summary.
    initial begin
        int tc, te;
        wait (done || wd);
        tc = checks + mon_checks + ep_checks;
        te = errs + mon_errs + ep_errs;
        if (wd && !done) begin
            tc++; te++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", tc, te);
        $finish;
    end
endmodule